// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the integer register file of a processor that gives every procedure its own view of 32 architectural registers while holding many procedure frames at once in a larger physical array. Eight architectural registers (indices 0 to 7) are common to all procedures. The other 24 are reached through a current window pointer. Neighbouring windows share eight registers, so arguments placed by a caller are seen directly by the callee.

Software reads two registers and writes one by architectural index, as a pipeline's decode and write-back stages would. A save command moves the pointer to a fresh window when a procedure is entered, and a restore command moves it back when the procedure returns. When no physical window is left for a save, or no caller window remains for a restore, the command is refused and a one-cycle trap pulse is raised so that system software can spill or fill frames.

Top module: `regwin_file`

## Requirements
- R1: Architectural registers 1 to 7 map to one shared physical set: a value written there reads back unchanged from every window.
- R2: Register 0 reads as zero on both read ports, and a write to it leaves nothing behind.
- R3: Registers 8 to 15 (outgoing group) of window w are the same storage as registers 24 to 31 (incoming group) of window w+1, index 8+k pairing with 24+k; registers 16 to 23 (private group) belong to one window only.
- R4: An accepted save raises the window pointer by one and an accepted restore lowers it by one, both modulo NWINDOWS; the pointer output changes on the clock edge that takes the command.
- R5: After reset one window is resident; a save while NWINDOWS-1 windows are resident is refused, the pointer holds, and the overflow output is high for exactly the one cycle after that edge.
- R6: A restore while only one window is resident is refused, the pointer holds, and the underflow output is high for exactly the one cycle after that edge.
- R7: Reads are combinational, a write takes effect at the clock edge, and a read of the register being written in that same cycle returns the incoming data.
- R8: Save and restore asserted together are both ignored: the pointer holds and neither trap is raised.
- R9: A write issued in the same cycle as a save or restore lands in the window that was current during that cycle.
- R10: Synchronous active-high reset sets the pointer to 0 and both trap outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Architectural index for read port A |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 5 | Architectural index for read port B |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural index to write |
| wr_data | input | DATA_W | Write data |
| save_req | input | 1 | Move to the next window (procedure entry) |
| restore_req | input | 1 | Move to the previous window (procedure return) |
| cwp | output | $clog2(NWINDOWS) | Current window pointer |
| ovf_trap | output | 1 | Refused save pulse |
| unf_trap | output | 1 | Refused restore pulse |

## Verification
A register write and a window move can fall in the same cycle, and so can a write and a read of the same register. The bench issues a write together with a save and later confirms, after restoring, that the data sits in the old window's private group while the new window's copy is untouched. It also drives a read index equal to the write index before the edge and compares the combinational output against the incoming data, then against the stored data after the edge.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int ARCH_REGS  = 32;
  localparam int GROUP_SIZE = 8;
  localparam int NUM_GLOBAL = GROUP_SIZE;
  localparam int WIN_SLOTS  = 2 * GROUP_SIZE;
  localparam int IDX_W      = $clog2(ARCH_REGS);

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_PRIV   = 2'd2,
    GRP_IN     = 2'd3
  } reg_group_e;

  function automatic reg_group_e group_of(input logic [IDX_W-1:0] idx);
    return reg_group_e'(idx[IDX_W-1 -: 2]);
  endfunction
endpackage

// File: rtl/regwin_map.sv
module regwin_map import regwin_pkg::*; #(
  parameter int NWINDOWS = 8,
  parameter int CWP_W    = $clog2(NWINDOWS),
  parameter int PHYS_W   = $clog2(NUM_GLOBAL + WIN_SLOTS * NWINDOWS)
) (
  input  logic [CWP_W-1:0]  cwp,
  input  logic [IDX_W-1:0]  arch_idx,
  output logic [PHYS_W-1:0] phys_idx
);
  localparam logic [CWP_W-1:0] LAST_WIN = CWP_W'(NWINDOWS - 1);

  logic [CWP_W-1:0]  caller;
  logic [PHYS_W-1:0] own_base;
  logic [PHYS_W-1:0] caller_base;
  logic [PHYS_W-1:0] offs;

  always_comb begin
    caller      = (cwp == '0) ? LAST_WIN : cwp - 1'b1;
    own_base    = PHYS_W'(NUM_GLOBAL) + PHYS_W'(cwp) * PHYS_W'(WIN_SLOTS);
    caller_base = PHYS_W'(NUM_GLOBAL) + PHYS_W'(caller) * PHYS_W'(WIN_SLOTS);
    offs        = PHYS_W'(arch_idx[2:0]);
    unique case (group_of(arch_idx))
      GRP_GLOBAL: phys_idx = offs;
      GRP_PRIV:   phys_idx = own_base + offs;
      GRP_OUT:    phys_idx = own_base + PHYS_W'(GROUP_SIZE) + offs;
      default:    phys_idx = caller_base + PHYS_W'(GROUP_SIZE) + offs;
    endcase
  end
endmodule

// File: rtl/regwin_ctl.sv
module regwin_ctl #(
  parameter int NWINDOWS = 8,
  parameter int CWP_W    = $clog2(NWINDOWS),
  parameter int USED_W   = $clog2(NWINDOWS) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             save_req,
  input  logic             restore_req,
  output logic [CWP_W-1:0] cwp,
  output logic             ovf_trap,
  output logic             unf_trap
);
  localparam logic [USED_W-1:0] MAX_USED = USED_W'(NWINDOWS - 1);
  localparam logic [CWP_W-1:0]  LAST_WIN = CWP_W'(NWINDOWS - 1);

  logic [USED_W-1:0] used_q;
  logic do_save, do_rest, save_full, rest_empty;

  assign do_save    = save_req & ~restore_req;
  assign do_rest    = restore_req & ~save_req;
  assign save_full  = (used_q == MAX_USED);
  assign rest_empty = (used_q == USED_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp      <= '0;
      used_q   <= USED_W'(1);
      ovf_trap <= 1'b0;
      unf_trap <= 1'b0;
    end else begin
      ovf_trap <= do_save & save_full;
      unf_trap <= do_rest & rest_empty;
      if (do_save && !save_full) begin
        cwp    <= (cwp == LAST_WIN) ? '0 : cwp + 1'b1;
        used_q <= used_q + 1'b1;
      end else if (do_rest && !rest_empty) begin
        cwp    <= (cwp == '0) ? LAST_WIN : cwp - 1'b1;
        used_q <= used_q - 1'b1;
      end
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_trap |-> $stable(cwp));
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    unf_trap |-> $stable(cwp));
  // R5
  trap_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ovf_trap && unf_trap));
  // R4
  resident_range_chk: assert property (@(posedge clk) disable iff (rst)
    (used_q >= USED_W'(1)) && (used_q <= MAX_USED));
  // R4
  save_step_chk: assert property (@(posedge clk) disable iff (rst)
    (do_save && !save_full) |=> (cwp == (($past(cwp) == LAST_WIN) ? '0 : $past(cwp) + 1'b1)));
  // R8
  both_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (save_req && restore_req) |=> ($stable(cwp) && !ovf_trap && !unf_trap));
endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 136,
  parameter int NREAD  = 2,
  parameter int PHYS_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic [PHYS_W-1:0]             waddr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NREAD-1:0][PHYS_W-1:0]  raddr,
  output logic [NREAD-1:0][DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NREAD; p++) begin : g_rd
    assign rdata[p] = (we && (waddr == raddr[p])) ? wdata : mem[raddr[p]];
  end
endmodule

// File: rtl/regwin_file.sv
module regwin_file import regwin_pkg::*; #(
  parameter int NWINDOWS = 8,
  parameter int DATA_W   = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [4:0]                  rd_a_idx,
  output logic [DATA_W-1:0]           rd_a_data,
  input  logic [4:0]                  rd_b_idx,
  output logic [DATA_W-1:0]           rd_b_data,
  input  logic                        wr_en,
  input  logic [4:0]                  wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        save_req,
  input  logic                        restore_req,
  output logic [$clog2(NWINDOWS)-1:0] cwp,
  output logic                        ovf_trap,
  output logic                        unf_trap
);
  localparam int CWP_W  = $clog2(NWINDOWS);
  localparam int DEPTH  = NUM_GLOBAL + WIN_SLOTS * NWINDOWS;
  localparam int PHYS_W = $clog2(DEPTH);
  localparam int NPORT  = 3;
  localparam int NREAD  = 2;

  logic [NPORT-1:0][IDX_W-1:0]  arch_idx;
  logic [NPORT-1:0][PHYS_W-1:0] phys_idx;
  logic [NREAD-1:0][DATA_W-1:0] raw;
  logic [CWP_W-1:0]             cwp_w;
  logic                         we;

  assign arch_idx[0] = rd_a_idx;
  assign arch_idx[1] = rd_b_idx;
  assign arch_idx[2] = wr_idx;
  assign we          = wr_en && (wr_idx != '0);

  regwin_ctl #(.NWINDOWS(NWINDOWS)) u_ctl (
    .clk(clk), .rst(rst), .save_req(save_req), .restore_req(restore_req),
    .cwp(cwp_w), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
  );
  assign cwp = cwp_w;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    regwin_map #(.NWINDOWS(NWINDOWS), .CWP_W(CWP_W), .PHYS_W(PHYS_W)) u_map (
      .cwp(cwp_w), .arch_idx(arch_idx[p]), .phys_idx(phys_idx[p])
    );
  end

  regwin_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NREAD(NREAD), .PHYS_W(PHYS_W)) u_store (
    .clk(clk), .we(we), .waddr(phys_idx[2]), .wdata(wr_data),
    .raddr(phys_idx[NREAD-1:0]), .rdata(raw)
  );

  assign rd_a_data = (rd_a_idx == '0) ? '0 : raw[0];
  assign rd_b_data = (rd_b_idx == '0) ? '0 : raw[1];

  // R7
  bypass_a_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx != '0) && (rd_a_idx == wr_idx)) |-> (rd_a_data == wr_data));
  // R2
  zero_b_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_b_idx == '0) |-> (raw[1] == '0 || rd_b_data == '0));
endmodule

// File: tb/regwin_file_test.sv
`timescale 1ns/1ps
module regwin_file_test;
  localparam int NW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
  logic [2:0] cwp;
  logic ovf_trap, unf_trap;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  regwin_file #(.NWINDOWS(NW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .save_req(save_req), .restore_req(restore_req),
    .cwp(cwp), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
  );

  function automatic logic [DW-1:0] gval(input int r);
    return 32'h0A00_0000 | DW'(r);
  endfunction
  function automatic logic [DW-1:0] pval(input int w, input int r);
    return 32'h1000_0000 | DW'(w << 8) | DW'(r);
  endfunction
  function automatic logic [DW-1:0] oval(input int w, input int r);
    return 32'h2000_0000 | DW'(w << 8) | DW'(r);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int r, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(r); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_a(input int r, output logic [DW-1:0] d);
    @(negedge clk);
    rd_a_idx = 5'(r);
    #1 d = rd_a_data;
  endtask

  task automatic rd_b(input int r, output logic [DW-1:0] d);
    @(negedge clk);
    rd_b_idx = 5'(r);
    #1 d = rd_b_data;
  endtask

  task automatic cmd(input logic s, input logic r);
    @(negedge clk);
    save_req = s; restore_req = r;
    @(negedge clk);
    save_req = 1'b0; restore_req = 1'b0;
  endtask

  task automatic check_frame(input int w);
    logic [DW-1:0] d;
    for (int r = 16; r < 24; r++) begin
      rd_a(r, d); chk("R3 private", d, pval(w, r));
    end
    for (int r = 8; r < 16; r++) begin
      rd_a(r, d); chk("R3 outgoing", d, oval(w, r));
    end
    if (w > 0)
      for (int r = 24; r < 32; r++) begin
        rd_b(r, d); chk("R3 incoming", d, oval(w - 1, r - 16));
      end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [DW-1:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R10 reset state
    chk("R10 cwp", DW'(cwp), 0);
    chk("R10 ovf", DW'(ovf_trap), 0);
    chk("R10 unf", DW'(unf_trap), 0);

    // R2 register zero
    wr(0, 32'hDEAD_BEEF);
    rd_a(0, d); chk("R2 port A", d, 0);
    rd_b(0, d); chk("R2 port B", d, 0);

    // R1 globals
    for (int r = 1; r < 8; r++) wr(r, gval(r));

    // sweep windows upward, R3 R4 R1
    for (int w = 0; w < NW - 1; w++) begin
      if (w > 0)
        for (int r = 24; r < 32; r++) begin
          rd_b(r, d); chk("R3 incoming", d, oval(w - 1, r - 16));
        end
      for (int r = 1; r < 8; r++) begin
        rd_b(r, d); chk("R1 global", d, gval(r));
      end
      for (int r = 8; r < 24; r++)
        wr(r, (r < 16) ? oval(w, r) : pval(w, r));
      if (w < NW - 2) begin
        cmd(1'b1, 1'b0);
        chk("R4 save cwp", DW'(cwp), DW'(w + 1));
        chk("R5 no ovf", DW'(ovf_trap), 0);
      end
    end

    // R5 overflow at full residency
    cmd(1'b1, 1'b0);
    chk("R5 ovf pulse", DW'(ovf_trap), 1);
    chk("R5 cwp held", DW'(cwp), DW'(NW - 2));
    @(negedge clk);
    chk("R5 ovf one cycle", DW'(ovf_trap), 0);

    // R7 same-cycle bypass then stored value
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd20; wr_data = 32'h5A5A_0020; rd_a_idx = 5'd20;
    #1 chk("R7 bypass", rd_a_data, 32'h5A5A_0020);
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R7 stored", rd_a_data, 32'h5A5A_0020);
    wr(20, pval(NW - 2, 20));

    // R8 both commands together
    cmd(1'b1, 1'b1);
    chk("R8 cwp held", DW'(cwp), DW'(NW - 2));
    chk("R8 no ovf", DW'(ovf_trap), 0);
    chk("R8 no unf", DW'(unf_trap), 0);

    // sweep down, R4 R3
    for (int w = NW - 3; w >= 0; w--) begin
      cmd(1'b0, 1'b1);
      chk("R4 restore cwp", DW'(cwp), DW'(w));
      chk("R6 no unf", DW'(unf_trap), 0);
      check_frame(w);
    end

    // R6 underflow
    cmd(1'b0, 1'b1);
    chk("R6 unf pulse", DW'(unf_trap), 1);
    chk("R6 cwp held", DW'(cwp), 0);
    @(negedge clk);
    chk("R6 unf one cycle", DW'(unf_trap), 0);

    // R9 write together with save goes to old window
    @(negedge clk);
    save_req = 1'b1; wr_en = 1'b1; wr_idx = 5'd16; wr_data = 32'hC0DE_0016;
    @(negedge clk);
    save_req = 1'b0; wr_en = 1'b0;
    chk("R9 cwp", DW'(cwp), 1);
    rd_a(16, d); chk("R9 new window untouched", d, pval(1, 16));
    cmd(1'b0, 1'b1);
    rd_a(16, d); chk("R9 old window written", d, 32'hC0DE_0016);

    // R1 globals survive all moves
    for (int r = 1; r < 8; r++) begin
      rd_a(r, d); chk("R1 global end", d, gval(r));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule